// File: doc/BRIEF.md
# Host Controller Interrupt Status Unit

This block keeps the interrupt bookkeeping of a USB host controller: a register of latched event flags, an enable mask, and one level-sensitive interrupt line. Eight internal event sources each pulse for one cycle when their condition occurs. A pulse latches a flag, and the flag stays set until software acknowledges it by writing a one to its position.

Software reaches the enable mask through two word addresses. One address only sets bits and the other only clears them. Both addresses read back the same mask. Bit 31 of the mask is a global gate on the line. The line is computed from the registered flags and mask, so it follows any change on the very next cycle.

The register port is a 32-bit, word-aligned write strobe with a combinational read path. Address decode above this block's three words is left to the surrounding controller.

Top module: `hcint_unit`

## Requirements
- R1: After reset the flag register reads 0, the enable mask reads 0x8000_0000, and `irq_o` is low.
- R2: A pulse on `evt_i[k]` sets flag bit k for k = 0..6 and flag bit 30 for k = 7. The flag is visible on the first read after the pulse.
- R3: A write to the flag word (byte offset 0x0C) clears each flag written as 1 and leaves the flags written as 0 unchanged.
- R4: A write to the enable-set word (byte offset 0x10) ORs the written value into the enable mask.
- R5: A write to the enable-clear word (byte offset 0x14) clears each mask bit written as 1.
- R6: Reading offset 0x10 and reading offset 0x14 both return the current enable mask.
- R7: `irq_o` is high exactly when mask bit 31 is set and at least one flag is set whose mask bit is also set. It reflects each change in the cycle after the change.
- R8: When an event pulse and a software clear hit the same flag in the same cycle, the flag stays set.
- R9: A write whose byte address has bits [1:0] not equal to 0 changes no register. A read at such an address returns 0.
- R10: Flag bits 7..29 and 31 and mask bits 7..29 always read 0, whatever is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_wr | input | 1 | Register write strobe |
| acc_addr | input | 8 | Byte address of the access |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for `acc_addr` (combinational) |
| evt_i | input | 8 | One-cycle event pulses. Index 7 is ownership change. |
| irq_o | output | 1 | Level interrupt line |

## Verification
Two functions can act on the same flag bit in the same cycle: a hardware event setting it and a software write clearing it. The bench provokes this by raising an event pulse on the same clock edge at which a flag-word write carries a one in that position. In a second case, that write clears one bit while an event arrives on a neighbouring bit. A read afterwards must show the contested bit still set. It must also show the neighbouring bit acted on independently, so a clear that outranks the event is caught.

// File: rtl/hcint_pkg.sv
package hcint_pkg;

    localparam int DATA_W  = 32;
    localparam int NUM_SRC = 8;
    localparam int MIE_POS = DATA_W - 1;
    localparam int OWN_POS = DATA_W - 2;

    // Flag position served by event source k; the last source sits just under the gate bit.
    function automatic int src_pos(input int k);
        return (k == NUM_SRC - 1) ? OWN_POS : k;
    endfunction

    function automatic logic [DATA_W-1:0] src_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            m[src_pos(k)] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [DATA_W-1:0] FLAG_MASK = src_mask();
    localparam logic [DATA_W-1:0] GATE_BIT  = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] MASK_IMPL = FLAG_MASK | GATE_BIT;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_FLAG,
        SEL_ENSET,
        SEL_ENCLR
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] flags;
    } flag_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] mask;
    } mask_state_t;

endpackage

// File: rtl/hcint_decode.sv
module hcint_decode
    import hcint_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] FLAG_OFS  = 8'h0C,
    parameter logic [ADDR_W-1:0] ENSET_OFS = 8'h10,
    parameter logic [ADDR_W-1:0] ENCLR_OFS = 8'h14
) (
    input  logic [ADDR_W-1:0] acc_addr,
    output reg_sel_e          sel
);
    logic aligned;

    always_comb begin
        aligned = (acc_addr[1:0] == 2'b00);
        sel     = SEL_NONE;
        if (aligned) begin
            if (acc_addr == FLAG_OFS) begin
                sel = SEL_FLAG;
            end else if (acc_addr == ENSET_OFS) begin
                sel = SEL_ENSET;
            end else if (acc_addr == ENCLR_OFS) begin
                sel = SEL_ENCLR;
            end
        end
    end
endmodule

// File: rtl/hcint_flags.sv
module hcint_flags
    import hcint_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ev_vec,
    input  logic              ack_we,
    input  logic [DATA_W-1:0] ack_val,
    output logic [DATA_W-1:0] flags
);
    flag_state_t st_d, st_q;
    logic [DATA_W-1:0] ack_bits;

    always_comb begin
        ack_bits     = ack_we ? ack_val : '0;
        // Event set is applied after the clear, so a simultaneous event wins.
        st_d.flags   = ((st_q.flags & ~ack_bits) | ev_vec) & FLAG_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flags;
endmodule

// File: rtl/hcint_mask.sv
module hcint_mask
    import hcint_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] wval,
    output logic [DATA_W-1:0] mask
);
    mask_state_t st_d, st_q;
    logic [DATA_W-1:0] set_bits;
    logic [DATA_W-1:0] clr_bits;

    always_comb begin
        set_bits   = set_we ? wval : '0;
        clr_bits   = clr_we ? wval : '0;
        st_d.mask  = ((st_q.mask | set_bits) & ~clr_bits) & MASK_IMPL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask <= GATE_BIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask = st_q.mask;
endmodule

// File: rtl/hcint_view.sv
module hcint_view
    import hcint_pkg::*;
(
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] flags,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic [DATA_W-1:0] pending;

    always_comb begin
        unique case (sel)
            SEL_FLAG:             rdata = flags;
            SEL_ENSET, SEL_ENCLR: rdata = mask;
            default:              rdata = '0;
        endcase
        pending = flags & mask & FLAG_MASK;
        irq     = mask[MIE_POS] && (pending != '0);
    end
endmodule

// File: rtl/hcint_unit.sv
module hcint_unit
    import hcint_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] FLAG_OFS  = 8'h0C,
    parameter logic [ADDR_W-1:0] ENSET_OFS = 8'h10,
    parameter logic [ADDR_W-1:0] ENCLR_OFS = 8'h14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_wr,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [DATA_W-1:0]  acc_wdata,
    output logic [DATA_W-1:0]  acc_rdata,
    input  logic [NUM_SRC-1:0] evt_i,
    output logic               irq_o
);
    reg_sel_e          sel;
    logic [DATA_W-1:0] ev_vec;
    logic [DATA_W-1:0] flag_vec;
    logic [DATA_W-1:0] mask_vec;

    hcint_decode #(
        .ADDR_W    (ADDR_W),
        .FLAG_OFS  (FLAG_OFS),
        .ENSET_OFS (ENSET_OFS),
        .ENCLR_OFS (ENCLR_OFS)
    ) dec_i (
        .acc_addr (acc_addr),
        .sel      (sel)
    );

    // Spread the event pulses onto their flag positions.
    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_evmap
            if (b < NUM_SRC - 1) begin : g_low
                assign ev_vec[b] = evt_i[b];
            end else if (b == OWN_POS) begin : g_own
                assign ev_vec[b] = evt_i[NUM_SRC-1];
            end else begin : g_none
                assign ev_vec[b] = 1'b0;
            end
        end
    endgenerate

    hcint_flags flags_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_vec  (ev_vec),
        .ack_we  (acc_wr && (sel == SEL_FLAG)),
        .ack_val (acc_wdata),
        .flags   (flag_vec)
    );

    hcint_mask mask_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (acc_wr && (sel == SEL_ENSET)),
        .clr_we (acc_wr && (sel == SEL_ENCLR)),
        .wval   (acc_wdata),
        .mask   (mask_vec)
    );

    hcint_view view_i (
        .sel   (sel),
        .flags (flag_vec),
        .mask  (mask_vec),
        .rdata (acc_rdata),
        .irq   (irq_o)
    );
endmodule

// File: rtl/hcint_unit_chk.sv
module hcint_unit_chk #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] FLAG_OFS  = 8'h0C,
    parameter logic [ADDR_W-1:0] ENSET_OFS = 8'h10,
    parameter logic [ADDR_W-1:0] ENCLR_OFS = 8'h14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_wr,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [31:0]       acc_wdata,
    input logic [7:0]        evt_i,
    input logic              irq_o,
    input logic [31:0]       flag_q,
    input logic [31:0]       mask_q
);
    // R2
    evt_low_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[0] |=> flag_q[0]);

    // R2
    evt_own_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[7] |=> flag_q[30]);

    // R3
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_addr == FLAG_OFS && acc_wdata[1] && !evt_i[1]) |=> !flag_q[1]);

    // R4
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_addr == ENSET_OFS && acc_wdata[0] && !acc_wdata[31]) |=> mask_q[0]);

    // R5
    gate_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_addr == ENCLR_OFS && acc_wdata[31]) |=> (!mask_q[31] && !irq_o));

    // R7
    gate_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q[31] |-> !irq_o);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_addr == FLAG_OFS && acc_wdata[2] && evt_i[2]) |=> flag_q[2]);

    // R9
    misaligned_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_addr[1:0] != 2'b00) |=> $stable(mask_q));
endmodule

bind hcint_unit hcint_unit_chk #(
    .ADDR_W    (ADDR_W),
    .FLAG_OFS  (FLAG_OFS),
    .ENSET_OFS (ENSET_OFS),
    .ENCLR_OFS (ENCLR_OFS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .evt_i     (evt_i),
    .irq_o     (irq_o),
    .flag_q    (flag_vec),
    .mask_q    (mask_vec)
);

// File: tb/hcint_unit_tb_top.sv
`timescale 1ns/1ps
module hcint_unit_tb_top;

    localparam logic [7:0] A_FLAG = 8'h0C;
    localparam logic [7:0] A_ESET = 8'h10;
    localparam logic [7:0] A_ECLR = 8'h14;

    localparam logic [1:0] K_WR  = 2'd0;
    localparam logic [1:0] K_EVT = 2'd1;
    localparam logic [1:0] K_RD  = 2'd2;
    localparam logic [1:0] K_IRQ = 2'd3;

    localparam int NV = 21;
    // {kind, requirement, address, data, expected}
    localparam logic [77:0] VEC [NV] = '{
        {K_RD,  4'd1,  A_ESET, 32'h0,         32'h8000_0000}, // R1 gate only
        {K_RD,  4'd1,  A_FLAG, 32'h0,         32'h0000_0000}, // R1 flags clear
        {K_EVT, 4'd2,  8'h00,  32'h01,        32'h0},
        {K_RD,  4'd2,  A_FLAG, 32'h0,         32'h0000_0001}, // R2 source 0
        {K_IRQ, 4'd7,  8'h00,  32'h0,         32'h0},         // R7 bit 0 masked
        {K_WR,  4'd4,  A_ESET, 32'h0000_0001, 32'h0},
        {K_RD,  4'd6,  A_ECLR, 32'h0,         32'h8000_0001}, // R6 alias, R4 OR
        {K_IRQ, 4'd7,  8'h00,  32'h0,         32'h1},         // R7 line up
        {K_EVT, 4'd2,  8'h00,  32'h80,        32'h0},
        {K_RD,  4'd2,  A_FLAG, 32'h0,         32'h4000_0001}, // R2 source 7 -> bit 30
        {K_WR,  4'd3,  A_FLAG, 32'h0000_0001, 32'h0},
        {K_RD,  4'd3,  A_FLAG, 32'h0,         32'h4000_0000}, // R3 partial clear
        {K_IRQ, 4'd7,  8'h00,  32'h0,         32'h0},         // R7 bit 30 masked
        {K_WR,  4'd4,  A_ESET, 32'hFFFF_FFFF, 32'h0},
        {K_RD,  4'd10, A_ESET, 32'h0,         32'hC000_007F}, // R10 R4
        {K_IRQ, 4'd7,  8'h00,  32'h0,         32'h1},
        {K_WR,  4'd5,  A_ECLR, 32'h8000_0000, 32'h0},
        {K_IRQ, 4'd5,  8'h00,  32'h0,         32'h0},         // R5 gate cleared
        {K_RD,  4'd5,  A_ESET, 32'h0,         32'h4000_007F}, // R5
        {K_WR,  4'd3,  A_FLAG, 32'hFFFF_FFFF, 32'h0},
        {K_RD,  4'd3,  A_FLAG, 32'h0,         32'h0000_0000}  // R3 full clear
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_wr = 1'b0;
    logic [7:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic [7:0]  evt_i = '0;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hcint_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_wr    (acc_wr),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata),
        .evt_i     (evt_i),
        .irq_o     (irq_o)
    );

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_wr = 1'b0;
    endtask

    task automatic do_event(input logic [7:0] m);
        @(negedge clk);
        evt_i = m;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic rd_check(input int req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        acc_addr = a;
        #1;
        check(req, acc_rdata, exp);
    endtask

    task automatic irq_check(input int req, input logic exp);
        @(negedge clk);
        #1;
        check(req, {31'd0, irq_o}, {31'd0, exp});
    endtask

    // Write and event on the same edge.
    task automatic clash(input logic [31:0] d, input logic [7:0] m);
        @(negedge clk);
        acc_wr = 1'b1; acc_addr = A_FLAG; acc_wdata = d; evt_i = m;
        @(negedge clk);
        acc_wr = 1'b0; evt_i = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        irq_check(1, 1'b0); // R1 line low after reset

        for (int i = 0; i < NV; i++) begin
            logic [77:0] v;
            v = VEC[i];
            case (v[77:76])
                K_WR:    do_write(v[71:64], v[63:32]);
                K_EVT:   do_event(v[39:32]);
                K_RD:    rd_check(int'(v[75:72]), v[71:64], v[31:0]);
                default: irq_check(int'(v[75:72]), v[0]);
            endcase
        end

        // R8 event and clear on the same flag in one cycle
        do_event(8'h04);
        clash(32'h0000_0004, 8'h04);
        rd_check(8, A_FLAG, 32'h0000_0004);
        // R8 with R3: clear bit 2 while bit 3 is raised
        clash(32'h0000_0004, 8'h08);
        rd_check(8, A_FLAG, 32'h0000_0008);

        // R9 misaligned write to enable-set, then misaligned flag write and read
        do_write(A_ESET + 8'h2, 32'h8000_0000);
        rd_check(9, A_ESET, 32'h4000_007F);
        irq_check(9, 1'b0);
        do_write(A_FLAG + 8'h1, 32'hFFFF_FFFF);
        rd_check(9, A_FLAG, 32'h0000_0008);
        rd_check(9, A_FLAG + 8'h3, 32'h0000_0000);

        // R7 gate back on with bit 3 pending and enabled
        do_write(A_ESET, 32'h8000_0000);
        irq_check(7, 1'b1);

        // R2 every source at once
        do_event(8'hFF);
        rd_check(2, A_FLAG, 32'h4000_007F);

        // R10 unimplemented mask bits stay zero
        do_write(A_ECLR, 32'hFFFF_FFFF);
        do_write(A_ESET, 32'h3FFF_FF80);
        rd_check(10, A_ECLR, 32'h0000_0000);
        irq_check(7, 1'b0);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_check(1, A_FLAG, 32'h0000_0000);
        rd_check(1, A_ECLR, 32'h8000_0000);
        irq_check(1, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule